// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from memory to a byte stream. It owns a single ring of descriptors held in an internal register table. Software fills a descriptor slot with a buffer address, a byte count and a few flags, then raises a free-running producer index. The engine serves descriptors in order, starting at its own consumer index and continuing until the two indices match. For each descriptor it fetches the buffer over a burst memory read port and forwards the bytes on a valid/ready/last stream. When the final byte has been accepted, the consumer index advances.

Both indices are 16 bits wide and keep counting upward. Descriptor slots are the low bits of an index, so the slot number wraps at the ring size while the index does not. Re-initialising the ring never clears the consumer index. Software re-aligns by copying the consumer value into the producer index. The append-CRC flag of each descriptor is carried alongside its bytes for the downstream MAC.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset the control bits, the producer index and the consumer index read back as 0, `mem_req` is low and `out_valid` is low.
- R2: The register address is 11 bits wide. With bit 10 clear, bits 9:2 select a descriptor slot and bits 1:0 select a word: 0 is the status word, 1 is the low address word, 2 is the high address word and 3 reads as 0. With bit 10 set, offset 0 is control (bit 0 is the global enable and bit 17 is the ring enable), offset 1 is the producer index and offset 2 is the consumer index, which is read-only. Written values read back.
- R3: A descriptor is started only when the global enable and the ring enable are both set and the producer index differs from the consumer index.
- R4: The descriptor served is slot (consumer index mod 256). Its byte count is status bits 27:16, EOP is status bit 14 and append-CRC is status bit 6. The buffer address is {high word, low word}.
- R5: Memory requests carry at most 8 beats and one byte per beat. Successive bursts of a descriptor cover consecutive addresses, and the last burst carries the remainder. `mem_req`, `mem_addr` and `mem_beats` hold steady until `mem_ack`.
- R6: Buffer bytes appear on `out_data` in address order. `out_last` is high only on the final byte of a descriptor whose EOP bit is set.
- R7: `out_crc` equals the descriptor's append-CRC bit on each of its bytes.
- R8: The consumer index increases by exactly one after the final byte of a descriptor is accepted.
- R9: A descriptor with byte count 0 causes no memory request, and the consumer index still advances by one.
- R10: Clearing the global enable while a descriptor is in flight lets that descriptor finish, and no further descriptor starts until the enable is set again.
- R11: The indices are free-running 16-bit counters: the consumer index wraps from 0xFFFF to 0 and the slot wraps from 255 to 0. Writes to control or the producer index never change the consumer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 11 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 64 | Burst start byte address |
| mem_beats | output | 4 | Burst length in bytes, 1 to 8 |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read byte valid |
| mem_rdata | input | 8 | Read byte |
| mem_rready | output | 1 | Read byte accepted |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |
| out_crc | output | 1 | Append-CRC flag of the current descriptor |

## Verification
The bench goes after the edges of the burst split: a 19-byte buffer must be fetched as 8, 8 and 3 beats at advancing addresses. An off-by-one in the remainder would over-read memory or hang waiting for a missing byte. Frames that span a descriptor without EOP check that a design keying `out_last` on the end of the descriptor alone would cut the frame in two. Zero-length descriptors check that a design which fetched a 0-beat burst would stall or issue an illegal request. The bench drops the global enable mid-frame, which a design that aborts on enable would truncate. It also drives the index through 0xFFFF back to 0 using slot 255, where a design that compared indices by magnitude or cleared the consumer on re-enable would stop or replay old slots.

// File: rtl/tx_ring_dma.sv
module tx_ring_dma #(
  parameter int NUM_DESC    = 256,
  parameter int IDX_W       = 16,
  parameter int LEN_W       = 12,
  parameter int MAX_BURST   = 8,
  parameter int RING_EN_BIT = 17
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [$clog2(NUM_DESC)+2:0] reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  output logic [$clog2(MAX_BURST):0] mem_beats,
  input  logic        mem_ack,
  input  logic        mem_rvalid,
  input  logic [7:0]  mem_rdata,
  output logic        mem_rready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        out_crc
);
  localparam int SLOT_W  = $clog2(NUM_DESC);
  localparam int BURST_W = $clog2(MAX_BURST) + 1;
  localparam int LEN_LSB = 16;
  localparam int EOP_BIT = 14;
  localparam int CRC_BIT = 6;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} state_t;
  state_t state;

  logic [31:0] stat_q [NUM_DESC];
  logic [31:0] alo_q  [NUM_DESC];
  logic [31:0] ahi_q  [NUM_DESC];

  logic             glb_en, ring_en;
  logic [IDX_W-1:0] prod_idx, cons_idx;
  logic [63:0]      cur_addr;
  logic [LEN_W-1:0] remain;
  logic [BURST_W-1:0] beat_cnt;
  logic             cur_eop, cur_crc;

  wire              ctl_sel  = reg_addr[SLOT_W+2];
  wire [SLOT_W-1:0] wr_slot  = reg_addr[SLOT_W+1:2];
  wire [SLOT_W-1:0] cur_slot = cons_idx[SLOT_W-1:0];
  wire [LEN_W-1:0]  nxt_len  = stat_q[cur_slot][LEN_LSB +: LEN_W];
  wire              pending  = prod_idx != cons_idx;
  wire              run      = glb_en && ring_en;
  wire              out_fire = out_valid && out_ready;
  wire              fin_byte = out_fire && beat_cnt == BURST_W'(1) && remain == '0;
  wire [BURST_W-1:0] burst   = (remain > LEN_W'(MAX_BURST)) ? BURST_W'(MAX_BURST)
                                                            : BURST_W'(remain);

  assign mem_req    = state == S_REQ;
  assign mem_addr   = cur_addr;
  assign mem_beats  = burst;
  assign mem_rready = state == S_DATA && out_ready;
  assign out_valid  = state == S_DATA && mem_rvalid;
  assign out_data   = mem_rdata;
  assign out_last   = cur_eop && beat_cnt == BURST_W'(1) && remain == '0;
  assign out_crc    = cur_crc;

  always_ff @(posedge clk) begin
    if (reg_we && !ctl_sel) begin
      case (reg_addr[1:0])
        2'd0: stat_q[wr_slot] <= reg_wdata;
        2'd1: alo_q[wr_slot]  <= reg_wdata;
        2'd2: ahi_q[wr_slot]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!ctl_sel) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = stat_q[wr_slot];
        2'd1: reg_rdata = alo_q[wr_slot];
        2'd2: reg_rdata = ahi_q[wr_slot];
        default: ;
      endcase
    end else begin
      case (reg_addr[1:0])
        2'd0: begin reg_rdata[0] = glb_en; reg_rdata[RING_EN_BIT] = ring_en; end
        2'd1: reg_rdata[IDX_W-1:0] = prod_idx;
        2'd2: reg_rdata[IDX_W-1:0] = cons_idx;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en   <= 1'b0;
      ring_en  <= 1'b0;
      prod_idx <= '0;
    end else if (reg_we && ctl_sel) begin
      if (reg_addr[1:0] == 2'd0) begin
        glb_en  <= reg_wdata[0];
        ring_en <= reg_wdata[RING_EN_BIT];
      end
      if (reg_addr[1:0] == 2'd1) prod_idx <= reg_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cons_idx <= '0;
      cur_addr <= '0;
      remain   <= '0;
      beat_cnt <= '0;
      cur_eop  <= 1'b0;
      cur_crc  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (run && pending) begin
          if (nxt_len == '0) begin
            cons_idx <= cons_idx + 1'b1;
          end else begin
            cur_addr <= {ahi_q[cur_slot], alo_q[cur_slot]};
            remain   <= nxt_len;
            cur_eop  <= stat_q[cur_slot][EOP_BIT];
            cur_crc  <= stat_q[cur_slot][CRC_BIT];
            state    <= S_REQ;
          end
        end
        S_REQ: if (mem_ack) begin
          beat_cnt <= burst;
          cur_addr <= cur_addr + 64'(burst);
          remain   <= remain - LEN_W'(burst);
          state    <= S_DATA;
        end
        S_DATA: if (out_fire) begin
          beat_cnt <= beat_cnt - 1'b1;
          if (beat_cnt == BURST_W'(1)) begin
            if (remain == '0) begin
              cons_idx <= cons_idx + 1'b1;
              state    <= S_IDLE;
            end else begin
              state    <= S_REQ;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_beats >= 1 && mem_beats <= MAX_BURST)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_beats))); // R5
  AST_CONS_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cons_idx == $past(cons_idx) || cons_idx == $past(cons_idx) + 1'b1)); // R8
  AST_LAST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (out_fire && out_last) |=> cons_idx == $past(cons_idx) + 1'b1); // R8
  AST_FIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    fin_byte |=> !out_valid); // R6
endmodule

// File: tb/tx_ring_dma_tb.sv
module tx_ring_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic [3:0]  mem_beats;
  logic        mem_ack = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_crc;

  always #2 clk = ~clk;

  tx_ring_dma dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit stall = 0;

  logic [7:0]  ob_data [4096];
  logic        ob_last [4096];
  logic        ob_crc  [4096];
  int          ob_n = 0;
  logic [63:0] rq_addr [512];
  int          rq_beats [512];
  int          rq_n = 0;

  logic [63:0] m_addr = '0;
  int          m_left = 0;
  int          cyc = 0;
  bit          snap_hs = 0, snap_acc = 0;
  logic [7:0]  s_data;
  logic        s_last, s_crc;
  logic [63:0] s_addr;
  int          s_beats;

  function automatic logic [7:0] pat(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] mkstat(input int len, input bit eop, input bit crc);
    return (32'(len) << 16) | (32'(eop) << 14) | (32'h1 << 13) | (32'(crc) << 6) | 32'h8000;
  endfunction

  initial forever begin
    @(negedge clk);
    if (rst) begin
      m_left = 0; mem_ack = 0; mem_rvalid = 0;
    end else begin
      if (snap_hs) begin
        ob_data[ob_n] = s_data; ob_last[ob_n] = s_last; ob_crc[ob_n] = s_crc;
        ob_n++; m_left--; m_addr++;
      end
      if (snap_acc) begin
        rq_addr[rq_n] = s_addr; rq_beats[rq_n] = s_beats; rq_n++;
        m_left = s_beats; m_addr = s_addr;
      end
      mem_ack    = mem_req && m_left == 0;
      mem_rvalid = m_left != 0;
      mem_rdata  = pat(m_addr);
      out_ready  = stall ? (cyc % 3 != 0) : 1'b1;
      cyc++;
    end
    #1;
    snap_hs  = out_valid && out_ready;
    snap_acc = mem_req && mem_ack;
    s_data = out_data; s_last = out_last; s_crc = out_crc;
    s_addr = mem_addr; s_beats = int'(mem_beats);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [10:0] daddr(input int slot, input int w);
    return {1'b0, 8'(slot), 2'(w)};
  endfunction

  localparam logic [10:0] A_CTRL = 11'h400, A_PROD = 11'h401, A_CONS = 11'h402;

  task automatic set_desc(input int slot, input int len, input bit eop, input bit crc,
                          input logic [63:0] base);
    reg_write(daddr(slot, 0), mkstat(len, eop, crc));
    reg_write(daddr(slot, 1), base[31:0]);
    reg_write(daddr(slot, 2), base[63:32]);
  endtask

  task automatic wait_cons(input int target, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 100000; i++) begin
      reg_read(A_CONS, v);
      if (v[15:0] == 16'(target)) begin ok = 1; break; end
    end
  endtask

  task automatic check_frame(input int first, input logic [63:0] base, input int len,
                             input bit eop, input bit crc, input string tag);
    bit good = 1;
    for (int i = 0; i < len; i++) begin
      if (ob_data[first+i] != pat(base + 64'(i))) good = 0;
      if (ob_last[first+i] != (eop && i == len - 1)) good = 0;
      if (ob_crc[first+i] != crc) good = 0;
    end
    check(good, tag, first, len);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    reg_read(A_PROD, v); check(v == 0, "R1 prod", v, 0);
    reg_read(A_CONS, v); check(v == 0, "R1 cons", v, 0);
    check(!mem_req && !out_valid, "R1 idle outputs", {mem_req, out_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(daddr(9, 0), 32'h1234_5678);
    reg_write(daddr(9, 1), 32'hCAFE_0001);
    reg_write(daddr(9, 2), 32'h0000_0042);
    reg_read(daddr(9, 0), v); check(v == 32'h1234_5678, "R2 status word", v, 32'h1234_5678);
    reg_read(daddr(9, 1), v); check(v == 32'hCAFE_0001, "R2 low word", v, 32'hCAFE_0001);
    reg_read(daddr(9, 2), v); check(v == 32'h42, "R2 high word", v, 32'h42);
    reg_read(daddr(9, 3), v); check(v == 0, "R2 word 3", v, 0);
    reg_write(A_CTRL, 32'hFFFF_FFFE);
    reg_read(A_CTRL, v); check(v == 32'h0002_0000, "R2 ctrl bits", v, 32'h0002_0000);
    reg_write(A_CTRL, 32'h0);
    reg_write(A_CONS, 32'h0000_0077);
    reg_read(A_CONS, v); check(v == 0, "R2 R11 consumer read-only", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    bit ok;
    int f;
    set_desc(0, 4, 1, 0, 64'h0000_0000_0000_1000);
    reg_write(A_CTRL, 32'h1);
    reg_write(A_PROD, 32'h1);
    repeat (20) @(negedge clk);
    reg_read(A_CONS, v);
    check(rq_n == 0 && v == 0, "R3 global only", rq_n, 0);
    reg_write(A_CTRL, 32'h2_0000);
    repeat (20) @(negedge clk);
    reg_read(A_CONS, v);
    check(rq_n == 0 && v == 0, "R3 ring only", rq_n, 0);
    f = ob_n;
    reg_write(A_CTRL, 32'h2_0001);
    wait_cons(1, ok);
    check(ok, "R3 R8 both enables start", ok, 1);
    check(ob_n - f == 4, "R4 byte count", ob_n - f, 4);
    check_frame(f, 64'h1000, 4, 1, 0, "R4 R6 frame bytes");
  endtask

  task automatic t_long();
    bit ok;
    int f, r;
    logic [63:0] b;
    b = 64'h0000_0001_0000_0100;
    set_desc(1, 19, 1, 1, b);
    f = ob_n; r = rq_n; stall = 1;
    reg_write(A_PROD, 32'h2);
    wait_cons(2, ok);
    stall = 0;
    check(ok, "R8 long frame done", ok, 1);
    check(rq_n - r == 3, "R5 burst count", rq_n - r, 3);
    check(rq_beats[r] == 8 && rq_beats[r+1] == 8 && rq_beats[r+2] == 3,
          "R5 burst split", rq_beats[r+2], 3);
    check(rq_addr[r] == b && rq_addr[r+1] == b + 8 && rq_addr[r+2] == b + 16,
          "R5 burst addresses", rq_addr[r+2], b + 16);
    check_frame(f, b, 19, 1, 1, "R6 R7 long frame with crc");
  endtask

  task automatic t_multi();
    bit ok;
    int f;
    set_desc(2, 5, 0, 0, 64'h3000);
    set_desc(3, 6, 1, 0, 64'h3100);
    f = ob_n;
    reg_write(A_PROD, 32'h4);
    wait_cons(4, ok);
    check(ok, "R8 two descriptors", ok, 1);
    check_frame(f, 64'h3000, 5, 0, 0, "R6 no last without EOP");
    check_frame(f + 5, 64'h3100, 6, 1, 0, "R6 last on EOP descriptor");
  endtask

  task automatic t_zero();
    bit ok;
    int f, r;
    set_desc(4, 0, 1, 0, 64'h4000);
    set_desc(5, 2, 1, 1, 64'h5000);
    f = ob_n; r = rq_n;
    reg_write(A_PROD, 32'h6);
    wait_cons(6, ok);
    check(ok, "R9 consumer advances over empty", ok, 1);
    check(rq_n - r == 1 && rq_addr[r] == 64'h5000, "R9 no fetch for empty", rq_n - r, 1);
    check_frame(f, 64'h5000, 2, 1, 1, "R9 following frame intact");
  endtask

  task automatic t_disable();
    logic [31:0] v;
    bit ok;
    int f;
    set_desc(6, 20, 1, 0, 64'h6000);
    set_desc(7, 3, 1, 0, 64'h7000);
    f = ob_n;
    reg_write(A_PROD, 32'h8);
    for (int i = 0; i < 200 && ob_n == f; i++) @(negedge clk);
    reg_write(A_CTRL, 32'h2_0000);
    repeat (60) @(negedge clk);
    reg_read(A_CONS, v);
    check(v == 7, "R10 frame finished then halt", v, 7);
    check(ob_n - f == 20, "R10 no truncation or next frame", ob_n - f, 20);
    check_frame(f, 64'h6000, 20, 1, 0, "R10 frame bytes");
    reg_write(A_CTRL, 32'h0);
    reg_read(A_CONS, v);
    check(v == 7, "R11 reinit keeps consumer", v, 7);
    reg_write(A_CTRL, 32'h2_0001);
    wait_cons(8, ok);
    check(ok, "R10 resumes after enable", ok, 1);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bit ok;
    int f;
    for (int s = 0; s < 256; s++) reg_write(daddr(s, 0), 32'h0000_8000);
    reg_write(A_PROD, 32'hFFFF);
    wait_cons(16'hFFFF, ok);
    check(ok, "R11 reaches 0xFFFF", ok, 1);
    set_desc(255, 3, 1, 0, 64'h2000);
    f = ob_n;
    reg_write(A_PROD, 32'h0);
    wait_cons(0, ok);
    check(ok, "R11 consumer wraps to 0", ok, 1);
    check_frame(f, 64'h2000, 3, 1, 0, "R11 R4 slot 255 served");
    reg_read(A_PROD, v);
    check(v == 0, "R11 producer kept", v, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_long();
    t_multi();
    t_zero();
    t_disable();
    t_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule